// File: doc/BRIEF.md
# Link Keepalive and Silence Monitor

This block keeps a point-to-point Ethernet link alive and watches it for silence. One programmable 8-bit timeout, counted in slot times (one slot time is 512 bit times and arrives as a single-cycle `slot_tick`), drives two watchers. The transmit watcher counts slot times in which the local transmitter sent nothing. When that count reaches half the timeout, it asks the MAC to send a heartbeat MAC control frame. The receive watcher counts slot times without a good received frame. When that count reaches the full timeout, it raises a sticky interrupt. A processor can also force out a MAC control frame that carries its own opcode. An arbiter passes one request at a time to the MAC through a request/acknowledge handshake. Building the frame, the CRC and the MAC datapath are handled elsewhere.

There are three state machines. The transmit idle timer has the states `TX_OFF`, `TX_COUNT` and `TX_PEND`. It goes OFF→COUNT when enabled and COUNT→PEND when the half period has elapsed. It goes PEND→COUNT when the heartbeat is acknowledged, and from any state to OFF when the timeout is zero. The receive watchdog has the states `RX_OFF`, `RX_WATCH` and `RX_EXPIRED`. It goes OFF→WATCH when enabled and WATCH→EXPIRED when the full period has elapsed, which raises the interrupt. It goes EXPIRED→WATCH when a good frame arrives, and from any state to OFF when the timeout is zero. The request arbiter has the states `ARB_IDLE`, `ARB_BEAT` and `ARB_FORCE`. It goes IDLE→FORCE when a forced frame is pending and IDLE→BEAT when only a heartbeat is pending. It goes BEAT→IDLE and FORCE→IDLE on acknowledge.

Top module: `link_keepalive_mon`

## Requirements
- R1: With timeout T≠0 and no `rx_good_frame`, `irq_timeout` rises after the T-th `slot_tick` and not after the (T-1)-th.
- R2: With timeout T≠0 and no transmit activity, `ctl_req` rises after H slot ticks with `ctl_opcode` equal to `cfg_beat_opcode`, where H = floor(T/2) (e.g. 0x0012 passes through unchanged).
- R3: Transmit activity restarts the transmit idle count. Transmit activity is a `tx_frame_done` pulse or any acknowledged request.
- R4: Only `rx_good_frame` restarts the receive silence count; transmit activity has no effect on it.
- R5: A `force_req` pulse produces a request whose `ctl_opcode` equals `cfg_force_opcode`.
- R6: When a forced frame and a heartbeat are both pending, the forced frame is requested first. The heartbeat stays pending and is requested after the forced frame is acknowledged.
- R7: `ctl_req` stays high until `ctl_ack`, and `ctl_opcode` is stable while it is held, even if the opcode registers change. `ctl_req` is low in the cycle after an acknowledge.
- R8: `irq_timeout` stays high until `irq_clear`. It fires only once per silence episode: it fires again only after a good frame has been received.
- R9: A timeout of zero disables both the heartbeat and the receive watchdog.
- R10: For an odd T the half period rounds down, with a minimum of one slot time: T=5 gives H=2 and T=1 gives H=1.
- R11: After reset `ctl_req` and `irq_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| tx_frame_done | input | 1 | Pulse: some frame was transmitted |
| rx_good_frame | input | 1 | Pulse: a good frame was received |
| force_req | input | 1 | Pulse: processor asks for a forced control frame |
| irq_clear | input | 1 | Pulse: clear the timeout interrupt |
| cfg_timeout | input | 8 | Timeout in slot times, 0 = disabled |
| cfg_beat_opcode | input | 16 | Opcode of the heartbeat frame |
| cfg_force_opcode | input | 16 | Opcode of the forced frame |
| ctl_ack | input | 1 | MAC accepts the current request |
| ctl_req | output | 1 | Control frame request, held until acknowledged |
| ctl_opcode | output | 16 | Opcode of the requested frame |
| irq_timeout | output | 1 | Sticky receive-silence interrupt |

## Verification
The bench probes the tick on which each watcher fires. A design with an off-by-one comparison would request or interrupt one slot early or late. A design that did not clamp the half period would never send a heartbeat at T=1. The bench collides a forced frame with a freshly pending heartbeat. It checks that the forced opcode goes first and that the heartbeat is not lost, which a design that cleared the pending heartbeat on transmit activity would get wrong. The bench also checks that transmit activity and repeated silence after `irq_clear` do not rearm or mask the interrupt, and that changing the opcode register under a held request leaves the presented opcode untouched.

// File: rtl/keepalive_pkg.sv
package keepalive_pkg;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_COUNT = 2'd1,
        TX_PEND  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_OFF     = 2'd0,
        RX_WATCH   = 2'd1,
        RX_EXPIRED = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_BEAT  = 2'd1,
        ARB_FORCE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/ka_tx_idle_timer.sv
module ka_tx_idle_timer
    import keepalive_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             tx_activity,
    input  logic             beat_sent,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             beat_pending
);

    localparam int CW = TMO_W + 1;

    tx_state_e          state_q, state_d;
    logic [TMO_W-1:0]   idle_cnt_q;
    logic [TMO_W-1:0]   half_period;
    logic               enabled;
    logic               reach;

    // half the timeout, rounded down, never below one slot
    always_comb begin
        half_period = cfg_timeout >> 1;
        if (half_period == '0) begin
            half_period = {{(TMO_W-1){1'b0}}, 1'b1};
        end
    end

    assign enabled = (cfg_timeout != '0);
    assign reach   = slot_tick && !tx_activity &&
                     (({1'b0, idle_cnt_q} + CW'(1)) >= {1'b0, half_period});

    always_comb begin
        state_d = state_q;
        if (!enabled) begin
            state_d = TX_OFF;
        end else begin
            unique case (state_q)
                TX_OFF:   state_d = TX_COUNT;
                TX_COUNT: if (reach) state_d = TX_PEND;
                TX_PEND:  if (beat_sent) state_d = TX_COUNT;
                default:  state_d = TX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
        end else if (state_q != TX_COUNT || state_d != TX_COUNT || tx_activity) begin
            idle_cnt_q <= '0;
        end else if (slot_tick) begin
            idle_cnt_q <= idle_cnt_q + TMO_W'(1);
        end
    end

    assign beat_pending = (state_q == TX_PEND);

endmodule

// File: rtl/ka_rx_watchdog.sv
module ka_rx_watchdog
    import keepalive_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             rx_good,
    input  logic             irq_clear,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic             irq
);

    localparam int CW = TMO_W + 1;

    rx_state_e          state_q, state_d;
    logic [TMO_W-1:0]   quiet_cnt_q;
    logic               enabled;
    logic               expire;
    logic               irq_q;

    assign enabled = (cfg_timeout != '0);
    assign expire  = slot_tick && !rx_good &&
                     (({1'b0, quiet_cnt_q} + CW'(1)) >= {1'b0, cfg_timeout});

    always_comb begin
        state_d = state_q;
        if (!enabled) begin
            state_d = RX_OFF;
        end else begin
            unique case (state_q)
                RX_OFF:     state_d = RX_WATCH;
                RX_WATCH:   if (expire) state_d = RX_EXPIRED;
                RX_EXPIRED: if (rx_good) state_d = RX_WATCH;
                default:    state_d = RX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt_q <= '0;
            irq_q       <= 1'b0;
        end else begin
            if (state_q != RX_WATCH || state_d != RX_WATCH || rx_good) begin
                quiet_cnt_q <= '0;
            end else if (slot_tick) begin
                quiet_cnt_q <= quiet_cnt_q + TMO_W'(1);
            end
            // a new expiry beats a simultaneous clear
            if (state_q == RX_WATCH && state_d == RX_EXPIRED) begin
                irq_q <= 1'b1;
            end else if (irq_clear) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/ka_req_arbiter.sv
module ka_req_arbiter
    import keepalive_pkg::*;
#(
    parameter int OPC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_req,
    input  logic             beat_pending,
    input  logic [OPC_W-1:0] cfg_beat_opcode,
    input  logic [OPC_W-1:0] cfg_force_opcode,
    input  logic             ctl_ack,
    output logic             ctl_req,
    output logic [OPC_W-1:0] ctl_opcode,
    output logic             beat_sent,
    output logic             force_sent
);

    arb_state_e       state_q, state_d;
    logic             force_pend_q;
    logic [OPC_W-1:0] opcode_q;

    assign beat_sent  = (state_q == ARB_BEAT)  && ctl_ack;
    assign force_sent = (state_q == ARB_FORCE) && ctl_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (force_pend_q)      state_d = ARB_FORCE;
                else if (beat_pending) state_d = ARB_BEAT;
            end
            ARB_BEAT:  if (ctl_ack) state_d = ARB_IDLE;
            ARB_FORCE: if (ctl_ack) state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // outputs: pending flag and opcode captured at grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_pend_q <= 1'b0;
            opcode_q     <= '0;
        end else begin
            if (force_req)       force_pend_q <= 1'b1;
            else if (force_sent) force_pend_q <= 1'b0;
            if (state_q == ARB_IDLE) begin
                if (state_d == ARB_FORCE)     opcode_q <= cfg_force_opcode;
                else if (state_d == ARB_BEAT) opcode_q <= cfg_beat_opcode;
            end
        end
    end

    assign ctl_req    = (state_q != ARB_IDLE);
    assign ctl_opcode = opcode_q;

endmodule

// File: rtl/link_keepalive_mon.sv
module link_keepalive_mon
    import keepalive_pkg::*;
#(
    parameter int TMO_W = 8,
    parameter int OPC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             tx_frame_done,
    input  logic             rx_good_frame,
    input  logic             force_req,
    input  logic             irq_clear,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [OPC_W-1:0] cfg_beat_opcode,
    input  logic [OPC_W-1:0] cfg_force_opcode,
    input  logic             ctl_ack,
    output logic             ctl_req,
    output logic [OPC_W-1:0] ctl_opcode,
    output logic             irq_timeout
);

    logic beat_pending;
    logic beat_sent;
    logic force_sent;
    logic tx_activity;

    // every frame leaving the port, ours included, counts as traffic
    assign tx_activity = tx_frame_done | beat_sent | force_sent;

    ka_tx_idle_timer #(.TMO_W(TMO_W)) tx_timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_tick    (slot_tick),
        .tx_activity  (tx_activity),
        .beat_sent    (beat_sent),
        .cfg_timeout  (cfg_timeout),
        .beat_pending (beat_pending)
    );

    ka_rx_watchdog #(.TMO_W(TMO_W)) rx_wd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_tick   (slot_tick),
        .rx_good     (rx_good_frame),
        .irq_clear   (irq_clear),
        .cfg_timeout (cfg_timeout),
        .irq         (irq_timeout)
    );

    ka_req_arbiter #(.OPC_W(OPC_W)) arb_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .force_req        (force_req),
        .beat_pending     (beat_pending),
        .cfg_beat_opcode  (cfg_beat_opcode),
        .cfg_force_opcode (cfg_force_opcode),
        .ctl_ack          (ctl_ack),
        .ctl_req          (ctl_req),
        .ctl_opcode       (ctl_opcode),
        .beat_sent        (beat_sent),
        .force_sent       (force_sent)
    );

endmodule

// File: rtl/keepalive_checker.sv
module keepalive_checker #(
    parameter int TMO_W = 8,
    parameter int OPC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_clear,
    input logic [TMO_W-1:0] cfg_timeout,
    input logic             ctl_ack,
    input logic             ctl_req,
    input logic [OPC_W-1:0] ctl_opcode,
    input logic             irq_timeout
);

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && !ctl_ack) |=> ctl_req);

    assert_opcode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && !ctl_ack) |=> $stable(ctl_opcode));

    assert_req_drops_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && ctl_ack) |=> !ctl_req);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_timeout && !irq_clear) |=> irq_timeout);

    assert_off_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout == '0) |=> !$rose(irq_timeout));

endmodule

bind link_keepalive_mon keepalive_checker #(.TMO_W(TMO_W), .OPC_W(OPC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_clear   (irq_clear),
    .cfg_timeout (cfg_timeout),
    .ctl_ack     (ctl_ack),
    .ctl_req     (ctl_req),
    .ctl_opcode  (ctl_opcode),
    .irq_timeout (irq_timeout)
);

// File: tb/link_keepalive_mon_tb_top.sv
`timescale 1ns/1ps
module link_keepalive_mon_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_tick = 1'b0;
    logic        tx_frame_done = 1'b0;
    logic        rx_good_frame = 1'b0;
    logic        force_req = 1'b0;
    logic        irq_clear = 1'b0;
    logic [7:0]  cfg_timeout = 8'd0;
    logic [15:0] cfg_beat_opcode = 16'h0012;
    logic [15:0] cfg_force_opcode = 16'h0001;
    logic        ctl_ack = 1'b0;
    logic        ctl_req;
    logic [15:0] ctl_opcode;
    logic        irq_timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    link_keepalive_mon dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .slot_tick        (slot_tick),
        .tx_frame_done    (tx_frame_done),
        .rx_good_frame    (rx_good_frame),
        .force_req        (force_req),
        .irq_clear        (irq_clear),
        .cfg_timeout      (cfg_timeout),
        .cfg_beat_opcode  (cfg_beat_opcode),
        .cfg_force_opcode (cfg_force_opcode),
        .ctl_ack          (ctl_ack),
        .ctl_req          (ctl_req),
        .ctl_opcode       (ctl_opcode),
        .irq_timeout      (irq_timeout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slot_tick = 1'b1;
            @(negedge clk) slot_tick = 1'b0;
        end
        idle(2);
    endtask

    task automatic pulse_tx;
        @(negedge clk) tx_frame_done = 1'b1;
        @(negedge clk) tx_frame_done = 1'b0;
    endtask

    task automatic pulse_rx;
        @(negedge clk) rx_good_frame = 1'b1;
        @(negedge clk) rx_good_frame = 1'b0;
    endtask

    task automatic do_ack;
        @(negedge clk) ctl_ack = 1'b1;
        @(negedge clk) ctl_ack = 1'b0;
    endtask

    task automatic restart(input logic [7:0] t);
        @(negedge clk) rst_n = 1'b0;
        cfg_timeout = t;
        idle(2);
        rst_n = 1'b1;
        idle(3);
    endtask

    task automatic t_reset;
        restart(8'd4);
        check("R11 req after reset", ctl_req, 0);
        check("R11 irq after reset", irq_timeout, 0);
    endtask

    task automatic t_heartbeat;
        restart(8'd4);
        tick(1);
        check("R2 no beat before half period", ctl_req, 0);
        tick(1);
        check("R2 beat at half period", ctl_req, 1);
        check("R2 beat opcode", ctl_opcode, 32'h0012);
        do_ack;
        check("R7 req low after ack", ctl_req, 0);
    endtask

    task automatic t_idle_restart;
        restart(8'd4);
        tick(1);
        pulse_tx;
        tick(1);
        check("R3 tx activity restarts idle count", ctl_req, 0);
        tick(1);
        check("R3 beat after restarted count", ctl_req, 1);
        do_ack;
        tick(1);
        check("R3 acked beat restarts idle count", ctl_req, 0);
    endtask

    task automatic t_rx_timeout;
        restart(8'd6);
        tick(2);
        pulse_rx;
        tick(5);
        check("R4 rx good restarts silence count", irq_timeout, 0);
        pulse_tx;
        tick(1);
        check("R1 irq at full timeout, tx ignored R4", irq_timeout, 1);
        tick(2);
        check("R8 irq sticky", irq_timeout, 1);
        @(negedge clk) irq_clear = 1'b1;
        @(negedge clk) irq_clear = 1'b0;
        check("R8 irq cleared", irq_timeout, 0);
        tick(8);
        check("R8 no refire in same episode", irq_timeout, 0);
        pulse_rx;
        tick(5);
        check("R1 no irq one tick early", irq_timeout, 0);
        tick(1);
        check("R8 refire after new episode", irq_timeout, 1);
    endtask

    task automatic t_force;
        restart(8'd8);
        @(negedge clk) force_req = 1'b1;
        @(negedge clk) force_req = 1'b0;
        idle(2);
        check("R5 forced request", ctl_req, 1);
        check("R5 forced opcode", ctl_opcode, 32'h0001);
        @(negedge clk) cfg_force_opcode = 16'h00AB;
        idle(4);
        check("R7 req held without ack", ctl_req, 1);
        check("R7 opcode stable while held", ctl_opcode, 32'h0001);
        do_ack;
        check("R7 req low after forced ack", ctl_req, 0);
        cfg_force_opcode = 16'h0001;
    endtask

    task automatic t_priority;
        restart(8'd8);
        tick(3);
        @(negedge clk) begin slot_tick = 1'b1; force_req = 1'b1; end
        @(negedge clk) begin slot_tick = 1'b0; force_req = 1'b0; end
        idle(2);
        check("R6 forced frame first", ctl_opcode, 32'h0001);
        check("R6 request up", ctl_req, 1);
        do_ack;
        idle(2);
        check("R6 heartbeat kept pending", ctl_req, 1);
        check("R6 heartbeat opcode after forced", ctl_opcode, 32'h0012);
        do_ack;
    endtask

    task automatic t_disable_and_odd;
        restart(8'd0);
        tick(20);
        check("R9 no heartbeat when off", ctl_req, 0);
        check("R9 no irq when off", irq_timeout, 0);
        restart(8'd5);
        tick(1);
        check("R10 odd timeout no beat after one", ctl_req, 0);
        tick(1);
        check("R10 odd timeout rounds down", ctl_req, 1);
        do_ack;
        restart(8'd1);
        tick(1);
        check("R10 minimum half period of one", ctl_req, 1);
        check("R1 timeout of one slot", irq_timeout, 1);
        do_ack;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_heartbeat();
        t_idle_restart();
        t_rx_timeout();
        t_force();
        t_priority();
        t_disable_and_odd();
        finish_run();
    end

endmodule